// File: doc/BRIEF.md
# Atomic Compare-and-Store Access Checker

This block decides whether an atomic compare-and-store may go ahead on its target page. Each cycle it can accept one check. A check carries the outcome of address translation (a nonzero error code, or zero for a hit), the read and write permissions of the page, the page's cache attribute, a flag that says whether a data cache is built in, a 6-bit atomic policy register and the virtual address. One cycle later the block reports whether the access faults, and with which cause code. On a fault it also latches the virtual address into a fault address register.

The policy register holds three 2-bit fields. The cache attribute of the page picks one of them, and a zero field forbids the atomic access on that kind of page. When no data cache exists, every page is handled as uncached. Faults are checked in a fixed order: translation first, then permission, then cache policy. Only the first fault that applies is reported.

Top module: `atomchk_top`

## Requirements
- R1: A check strobed on `chk_valid` at a rising clock edge gives its result on `res_valid`, `res_fault` and `res_cause` right after the next rising edge. A new check may be strobed on every cycle. `res_valid` is low in any cycle that follows an edge with no strobe. After reset all outputs are zero.
- R2: A nonzero `xlat_code` is reported unchanged as `res_cause`, with `res_fault` high. A code of zero means the translation hit.
- R3: A hit where `perm_rd` or `perm_wr` is low reports the store-prohibited cause (parameter `CAUSE_STORE_PROHIB`, default 29). No load-prohibited cause is ever produced.
- R4: When `dcache_present` is low, the policy field at bits 1:0 governs the check whatever `page_attr` holds, including the isolate value.
- R5: With a data cache present, `page_attr` 0 (uncached) selects `atom_ctl[1:0]`, 1 (write-through) selects `atom_ctl[3:2]` and 2 (write-back) selects `atom_ctl[5:4]`. A zero in the selected field reports the load/store-error cause (parameter `CAUSE_LS_ERROR`, default 3).
- R6: With a data cache present, `page_attr` 3 (isolate) always reports the load/store-error cause, whatever the policy field holds.
- R7: With a data cache present, `page_attr` values 4 to 7 cause no policy fault. A hit with full permission on such a page reports `res_fault` low and `res_cause` zero.
- R8: A translation fault or a permission fault takes priority over a policy fault, and only the higher-priority cause is reported.
- R9: `fault_addr` takes the virtual address of a check that faults, in the same cycle the result appears. A check that does not fault leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chk_valid | input | 1 | Strobe that starts a check this cycle |
| xlat_code | input | CAUSE_W | Translation result: 0 = hit, otherwise the error cause |
| perm_rd | input | 1 | Page is readable |
| perm_wr | input | 1 | Page is writable |
| page_attr | input | 3 | Cache attribute: 0 uncached, 1 write-through, 2 write-back, 3 isolate, 4-7 other |
| dcache_present | input | 1 | A data cache is configured |
| atom_ctl | input | 6 | Three 2-bit atomic policy fields |
| vaddr | input | ADDR_W | Virtual address of the access |
| res_valid | output | 1 | Result strobe, one cycle after `chk_valid` |
| res_fault | output | 1 | The checked access must raise an exception |
| res_cause | output | CAUSE_W | Exception cause, zero when there is no fault |
| fault_addr | output | ADDR_W | Virtual address of the most recent faulting check |

## Verification
The bench targets the cases where two rules overlap. An isolate page in a design without a data cache must fall back to the uncached field; a design that gets this wrong faults on every such access. A permission or translation fault on a page whose policy field is zero must not report the policy cause; a design with the priority reversed reports cause 3. A write-through attribute must pick the middle field; a design with the field mapping shifted lets forbidden atomics through or blocks allowed ones. The bench also runs back-to-back strobes and idle cycles, so that a result that is late, repeated, or that updates `fault_addr` on a passing check shows up as a mismatch.

// File: rtl/atomchk_pkg.sv
package atomchk_pkg;
   localparam int ATTR_W = 3;
   localparam logic [ATTR_W-1:0] ATTR_UNCACHED = 3'd0;
   localparam logic [ATTR_W-1:0] ATTR_WTHRU    = 3'd1;
   localparam logic [ATTR_W-1:0] ATTR_WBACK    = 3'd2;
   localparam logic [ATTR_W-1:0] ATTR_ISOLATE  = 3'd3;

   typedef enum logic [1:0] {
      FC_NONE   = 2'd0,
      FC_XLAT   = 2'd1,
      FC_PERM   = 2'd2,
      FC_POLICY = 2'd3
   } fault_class_e;
endpackage

// File: rtl/atomchk_access.sv
module atomchk_access
   import atomchk_pkg::*;
#(
   parameter int CAUSE_W = 6,
   parameter logic [CAUSE_W-1:0] CAUSE_STORE_PROHIB = 6'd29
) (
   input  logic [CAUSE_W-1:0] xlat_code,
   input  logic               perm_rd,
   input  logic               perm_wr,
   output fault_class_e       acc_class,
   output logic [CAUSE_W-1:0] acc_cause
);
   always_comb begin
      acc_class = FC_NONE;
      acc_cause = '0;
      if (xlat_code != '0) begin
         acc_class = FC_XLAT;
         acc_cause = xlat_code;
      end else if (!(perm_rd && perm_wr)) begin
         acc_class = FC_PERM;
         acc_cause = CAUSE_STORE_PROHIB;
      end
   end
endmodule

// File: rtl/atomchk_policy.sv
module atomchk_policy
   import atomchk_pkg::*;
#(
   parameter int FIELD_W    = 2,
   parameter int NUM_FIELDS = 3,
   localparam int CTL_W     = FIELD_W * NUM_FIELDS
) (
   input  logic [ATTR_W-1:0] page_attr,
   input  logic              dcache_present,
   input  logic [CTL_W-1:0]  atom_ctl,
   output logic              pol_fault
);
   logic [FIELD_W-1:0] fld [NUM_FIELDS];
   logic [ATTR_W-1:0]  eff_attr;
   logic [FIELD_W-1:0] sel_fld;
   logic               sel_hit;

   for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_fld
      assign fld[g] = atom_ctl[g*FIELD_W +: FIELD_W];
   end

   assign eff_attr = dcache_present ? page_attr : ATTR_UNCACHED;

   always_comb begin
      sel_fld = '0;
      sel_hit = 1'b0;
      for (int i = 0; i < NUM_FIELDS; i++) begin
         if (eff_attr == ATTR_W'(i)) begin
            sel_fld = fld[i];
            sel_hit = 1'b1;
         end
      end
   end

   assign pol_fault = (eff_attr == ATTR_ISOLATE) || (sel_hit && sel_fld == '0);
endmodule

// File: rtl/atomchk_top.sv
module atomchk_top
   import atomchk_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int CAUSE_W    = 6,
   parameter int FIELD_W    = 2,
   parameter int NUM_FIELDS = 3,
   parameter logic [CAUSE_W-1:0] CAUSE_STORE_PROHIB = 6'd29,
   parameter logic [CAUSE_W-1:0] CAUSE_LS_ERROR     = 6'd3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               chk_valid,
   input  logic [CAUSE_W-1:0] xlat_code,
   input  logic               perm_rd,
   input  logic               perm_wr,
   input  logic [2:0]         page_attr,
   input  logic               dcache_present,
   input  logic [5:0]         atom_ctl,
   input  logic [ADDR_W-1:0]  vaddr,
   output logic               res_valid,
   output logic               res_fault,
   output logic [CAUSE_W-1:0] res_cause,
   output logic [ADDR_W-1:0]  fault_addr
);
   localparam int CTL_W = FIELD_W * NUM_FIELDS;

   if (CTL_W != 6) begin : g_bad_ctl
      $error("atom_ctl port is 6 bits wide; FIELD_W*NUM_FIELDS must be 6");
   end
   if (NUM_FIELDS > 3) begin : g_bad_nf
      $error("policy field count collides with the isolate attribute");
   end
   if (CAUSE_STORE_PROHIB == '0 || CAUSE_LS_ERROR == '0) begin : g_bad_cause
      $error("cause codes must be nonzero");
   end

   fault_class_e       acc_class;
   logic [CAUSE_W-1:0] acc_cause;
   logic               pol_fault;
   logic               nxt_fault;
   logic [CAUSE_W-1:0] nxt_cause;

   atomchk_access #(
      .CAUSE_W(CAUSE_W),
      .CAUSE_STORE_PROHIB(CAUSE_STORE_PROHIB)
   ) u_access (
      .xlat_code(xlat_code),
      .perm_rd  (perm_rd),
      .perm_wr  (perm_wr),
      .acc_class(acc_class),
      .acc_cause(acc_cause)
   );

   atomchk_policy #(
      .FIELD_W   (FIELD_W),
      .NUM_FIELDS(NUM_FIELDS)
   ) u_policy (
      .page_attr     (page_attr),
      .dcache_present(dcache_present),
      .atom_ctl      (atom_ctl[CTL_W-1:0]),
      .pol_fault     (pol_fault)
   );

   always_comb begin
      if (acc_class != FC_NONE) begin
         nxt_fault = 1'b1;
         nxt_cause = acc_cause;
      end else if (pol_fault) begin
         nxt_fault = 1'b1;
         nxt_cause = CAUSE_LS_ERROR;
      end else begin
         nxt_fault = 1'b0;
         nxt_cause = '0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid  <= 1'b0;
         res_fault  <= 1'b0;
         res_cause  <= '0;
         fault_addr <= '0;
      end else begin
         res_valid <= chk_valid;
         res_fault <= chk_valid && nxt_fault;
         res_cause <= chk_valid ? nxt_cause : '0;
         if (chk_valid && nxt_fault) fault_addr <= vaddr;
      end
   end
endmodule

// File: rtl/atomchk_sva.sv
module atomchk_sva #(
   parameter int ADDR_W  = 32,
   parameter int CAUSE_W = 6,
   parameter logic [CAUSE_W-1:0] CAUSE_LS_ERROR = 6'd3
) (
   input logic               clk,
   input logic               rst_n,
   input logic               chk_valid,
   input logic [CAUSE_W-1:0] xlat_code,
   input logic               perm_rd,
   input logic               perm_wr,
   input logic [2:0]         page_attr,
   input logic               dcache_present,
   input logic [ADDR_W-1:0]  vaddr,
   input logic               res_valid,
   input logic               res_fault,
   input logic [CAUSE_W-1:0] res_cause,
   input logic [ADDR_W-1:0]  fault_addr
);
   AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      chk_valid |=> res_valid); // R1
   AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
      !chk_valid |=> !res_valid && !res_fault); // R1
   AST_XLAT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      chk_valid && xlat_code != '0 |=> res_fault && res_cause == $past(xlat_code)); // R2
   AST_ISOLATE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      chk_valid && xlat_code == '0 && perm_rd && perm_wr && dcache_present && page_attr == 3'd3
      |=> res_cause == CAUSE_LS_ERROR); // R6
   AST_OTHER_ATTR_OK: assert property (@(posedge clk) disable iff (!rst_n)
      chk_valid && xlat_code == '0 && perm_rd && perm_wr && dcache_present && page_attr[2]
      |=> !res_fault && res_cause == '0); // R7
   AST_ADDR_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid && res_fault |-> fault_addr == $past(vaddr)); // R9
   AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !res_fault |-> $stable(fault_addr)); // R9
endmodule

bind atomchk_top atomchk_sva #(
   .ADDR_W(ADDR_W), .CAUSE_W(CAUSE_W), .CAUSE_LS_ERROR(CAUSE_LS_ERROR)
) u_sva (
   .clk(clk), .rst_n(rst_n), .chk_valid(chk_valid), .xlat_code(xlat_code),
   .perm_rd(perm_rd), .perm_wr(perm_wr), .page_attr(page_attr),
   .dcache_present(dcache_present), .vaddr(vaddr), .res_valid(res_valid),
   .res_fault(res_fault), .res_cause(res_cause), .fault_addr(fault_addr)
);

// File: tb/atomchk_top_bench.sv
module atomchk_top_bench;
   localparam int AW = 32;
   localparam int CW = 6;
   localparam logic [CW-1:0] SP = 6'd29;
   localparam logic [CW-1:0] LE = 6'd3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          chk_valid = 1'b0;
   logic [CW-1:0] xlat_code = '0;
   logic          perm_rd = 1'b0, perm_wr = 1'b0;
   logic [2:0]    page_attr = '0;
   logic          dcache_present = 1'b0;
   logic [5:0]    atom_ctl = '0;
   logic [AW-1:0] vaddr = '0;
   logic          res_valid, res_fault;
   logic [CW-1:0] res_cause;
   logic [AW-1:0] fault_addr;

   int total = 0;
   int bad = 0;
   int cyc = 0;

   // expectations for the result due at the next sampling point
   logic          e_valid = 1'b0;
   logic          e_fault = 1'b0;
   logic [CW-1:0] e_cause = '0;
   logic [AW-1:0] e_addr = '0;
   string         e_req = "R1";

   always #2 clk = ~clk;

   atomchk_top u_atomchk_top (
      .clk(clk), .rst_n(rst_n), .chk_valid(chk_valid), .xlat_code(xlat_code),
      .perm_rd(perm_rd), .perm_wr(perm_wr), .page_attr(page_attr),
      .dcache_present(dcache_present), .atom_ctl(atom_ctl), .vaddr(vaddr),
      .res_valid(res_valid), .res_fault(res_fault), .res_cause(res_cause),
      .fault_addr(fault_addr)
   );

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         total++; bad++;
         $display("FAIL watchdog R1 act=%0d exp=<20000", cyc);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   function automatic logic [CW-1:0] ref_cause(logic [CW-1:0] xc, logic rd, logic wr,
                                                logic [2:0] at, logic dc, logic [5:0] ctl);
      logic [2:0] ea;
      if (xc != '0) return xc;
      if (!(rd && wr)) return SP;
      ea = dc ? at : 3'd0;
      if (ea == 3'd3) return LE;
      if (ea < 3'd3 && ctl[2*ea +: 2] == 2'b00) return LE;
      return '0;
   endfunction

   function automatic string ref_req(logic [CW-1:0] xc, logic rd, logic wr,
                                     logic [2:0] at, logic dc);
      if (xc != '0) return "R2";
      if (!(rd && wr)) return "R3";
      if (!dc) return "R4";
      if (at == 3'd3) return "R6";
      if (at[2]) return "R7";
      return "R5";
   endfunction

   task automatic check(string req, string what, logic [AW-1:0] act, logic [AW-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
      end
   endtask

   // compare previous cycle's expectation, then drive a new check (or idle)
   task automatic step(logic v, logic [CW-1:0] xc, logic rd, logic wr, logic [2:0] at,
                       logic dc, logic [5:0] ctl, logic [AW-1:0] va, string req_override);
      @(negedge clk);
      check(e_req, "res_valid", AW'(res_valid), AW'(e_valid));
      check(e_req, "res_fault", AW'(res_fault), AW'(e_fault));
      check(e_req, "res_cause", AW'(res_cause), AW'(e_cause));
      check("R9", "fault_addr", fault_addr, e_addr);
      chk_valid = v; xlat_code = xc; perm_rd = rd; perm_wr = wr; page_attr = at;
      dcache_present = dc; atom_ctl = ctl; vaddr = va;
      e_valid = v;
      e_cause = v ? ref_cause(xc, rd, wr, at, dc, ctl) : '0;
      e_fault = v && (e_cause != '0);
      if (e_fault) e_addr = va;
      e_req = (req_override != "") ? req_override : (v ? ref_req(xc, rd, wr, at, dc) : "R1");
   endtask

   initial begin
      void'($urandom(32'h5eed_1234));
      repeat (3) @(negedge clk);
      check("R1", "reset res_valid", AW'(res_valid), '0);
      check("R1", "reset res_cause", AW'(res_cause), '0);
      check("R9", "reset fault_addr", fault_addr, '0);
      rst_n = 1'b1;
      // directed corners
      step(1, 6'd0,  1, 1, 3'd3, 0, 6'b111101, 32'h1000_0004, "R4");  // isolate, no cache -> ok
      step(1, 6'd0,  1, 1, 3'd2, 0, 6'b111100, 32'h1000_0008, "R4");  // no cache, bypass zero
      step(1, 6'd0,  1, 1, 3'd1, 1, 6'b110011, 32'h2000_0000, "R5");  // WT field zero
      step(1, 6'd0,  1, 1, 3'd1, 1, 6'b000100, 32'h2000_0010, "R5");  // WT allowed
      step(1, 6'd0,  1, 1, 3'd2, 1, 6'b001111, 32'h2000_0020, "R5");  // WB field zero
      step(0, 6'd0,  0, 0, 3'd0, 0, 6'b0,      32'hdead_beef, "R1");  // idle
      step(1, 6'd0,  1, 1, 3'd3, 1, 6'b111111, 32'h3000_0000, "R6");
      step(1, 6'd0,  1, 1, 3'd5, 1, 6'b000000, 32'h3000_0040, "R7");
      step(1, 6'd0,  1, 0, 3'd3, 1, 6'b000000, 32'h4000_0000, "R8");  // perm beats isolate
      step(1, 6'd0,  0, 1, 3'd0, 1, 6'b000000, 32'h4000_0100, "R3");
      step(1, 6'd26, 0, 0, 3'd1, 1, 6'b000000, 32'h5000_0000, "R8");  // xlat beats all
      step(1, 6'd63, 1, 1, 3'd4, 1, 6'b111111, 32'h5000_0200, "R2");
      step(1, 6'd0,  1, 1, 3'd0, 1, 6'b000001, 32'h6000_0000, "R9");  // pass: addr held
      // random mix, back-to-back with occasional idles
      for (int i = 0; i < 800; i++) begin
         logic [CW-1:0] xc;
         xc = ($urandom % 4 == 0) ? CW'($urandom) : '0;
         step(($urandom % 8) != 0, xc, ($urandom % 5) != 0, ($urandom % 5) != 0,
              3'($urandom), ($urandom % 4) != 0, 6'($urandom), $urandom, "");
      end
      step(0, 6'd0, 0, 0, 3'd0, 0, 6'b0, 32'h0, "R1");
      step(0, 6'd0, 0, 0, 3'd0, 0, 6'b0, 32'h0, "R1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule